// File: doc/BRIEF.md
# Chained Vector Multiply-Add Unit

This block evaluates Y = a*X + Y over a pair of vector register arrays holding up to 64 integer elements of 64 bits. A start pulse captures a scalar `a` and a vector length. An issue sequencer then walks the element indices one per clock and reads X at the current index. Each X element passes through a seven-stage multiply pipeline. As soon as a product leaves that pipeline it is added to the matching Y element in a six-stage add pipeline. The add does not wait for the whole multiply pass to end. Each sum goes out through a single write port into a result register array.

Because the two units are chained element by element, a run of n elements takes n + 13 cycles instead of two full passes. Arithmetic wraps modulo 2^64. The stage counts are parameters, so the same structure can model other unit latencies. The register arrays are outside the block and are read combinationally. X is read at the issue index, and Y is read at the index of the product that is leaving the multiplier.

Top module: `vmac_chain`

## Requirements
- R1: Each write carries address i and data (a*X[i] + Y[i]) mod 2^64, where a is the scalar captured at start. Element i of X pairs only with element i of Y.
- R2: Writes go out on consecutive clock cycles, one element per cycle, in ascending address order from 0 to n-1, with no extra writes.
- R3: With start sampled at clock edge E0, the write for element i is visible in the cycle after edge E0+13+i. The 7 multiply stages and 6 add stages are chained per element.
- R4: For a length n from 1 to 64, `done_o` is a single-cycle pulse that is visible after edge E0+n+13. No write is active while it is high.
- R5: A length of 0 makes no writes, and `done_o` pulses in the cycle after edge E0+1.
- R6: A start pulse that arrives while a run is in progress is ignored. The run in progress keeps its length, its scalar and its done timing.
- R7: While reset is active and right after it is released, `done_o` and `wr_en_o` are low.
- R8: The scalar and the length are sampled only at an accepted start. Changing `scalar_i` or `len_i` during a run has no effect on the results.
- R9: A length above 64 is clamped to 64. Such a run writes 64 elements and pulses done after edge E0+77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| len_i | input | 7 | Vector length, 0 to 127, clamped to 64 |
| scalar_i | input | 64 | Scalar multiplier a |
| x_addr_o | output | 6 | X array read index |
| x_data_i | input | 64 | X array read data (combinational) |
| y_addr_o | output | 6 | Y array read index |
| y_data_i | input | 64 | Y array read data (combinational) |
| wr_en_o | output | 1 | Result array write enable |
| wr_addr_o | output | 6 | Result array write index |
| wr_data_o | output | 64 | Result array write data |
| done_o | output | 1 | Run complete pulse |

## Verification
The bench timestamps every write against the start edge. A design that waited for the whole multiply pass to finish, or that lost a stage of chaining, would show a first write later than 13 cycles after start and a late done pulse. Runs of 1, 64 and 100 elements probe the ends of the index counter. An off-by-one there would drop or duplicate the last write, or wrap the address past 63. A zero-length run catches a design that issues one spurious element or never signals done. A second start with a new scalar and length is sent mid-run. A design that accepted it would restart indices, change results or move the done pulse. Operands near 2^64 expose any sign or width error in the product.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  localparam int ELEM_W     = 64;
  localparam int VEC_MAX    = 64;
  localparam int MUL_STAGES = 7;
  localparam int ADD_STAGES = 6;
endpackage

// File: rtl/vmac_seq.sv
module vmac_seq #(
  parameter int MAX_LEN = 64,
  parameter int IW      = 6,
  parameter int LW      = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          fin_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          zero_o,
  output logic          issue_valid_o,
  output logic          issue_last_o,
  output logic [IW-1:0] issue_idx_o
);
  logic          busy_q, run_q, zero_q;
  logic [IW-1:0] idx_q, last_q;
  logic [LW-1:0] eff_len;

  assign eff_len  = (len_i > LW'(MAX_LEN)) ? LW'(MAX_LEN) : len_i;
  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      zero_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      zero_q <= accept_o && (eff_len == '0);
      if (accept_o && (eff_len != '0)) begin
        busy_q <= 1'b1;
        run_q  <= 1'b1;
        idx_q  <= '0;
        last_q <= IW'(eff_len - LW'(1));
      end else begin
        if (run_q) begin
          if (idx_q == last_q) run_q <= 1'b0;
          else                 idx_q <= idx_q + IW'(1);
        end
        if (fin_i) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o        = busy_q;
  assign zero_o        = zero_q;
  assign issue_valid_o = run_q;
  assign issue_last_o  = (idx_q == last_q);
  assign issue_idx_o   = idx_q;
endmodule

// File: rtl/vmac_pipe.sv
module vmac_pipe #(
  parameter int LAT = 7,
  parameter int DW  = 64,
  parameter int IW  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  input  logic [IW-1:0] in_idx_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic          out_last_o,
  output logic [IW-1:0] out_idx_o,
  output logic [DW-1:0] out_data_o
);
  logic          v_q [LAT];
  logic          l_q [LAT];
  logic [IW-1:0] i_q [LAT];
  logic [DW-1:0] d_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          l_q[0] <= 1'b0;
          i_q[0] <= '0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_valid_i;
          l_q[0] <= in_last_i;
          i_q[0] <= in_idx_i;
          d_q[0] <= in_data_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= 1'b0;
          l_q[s] <= 1'b0;
          i_q[s] <= '0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          l_q[s] <= l_q[s-1];
          i_q[s] <= i_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_last_o  = l_q[LAT-1];
  assign out_idx_o   = i_q[LAT-1];
  assign out_data_o  = d_q[LAT-1];
endmodule

// File: rtl/vmac_chain.sv
module vmac_chain
  import vmac_pkg::*;
#(
  parameter int DW      = ELEM_W,
  parameter int MAX_LEN = VEC_MAX,
  parameter int MUL_LAT = MUL_STAGES,
  parameter int ADD_LAT = ADD_STAGES,
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] scalar_i,
  output logic [IW-1:0] x_addr_o,
  input  logic [DW-1:0] x_data_i,
  output logic [IW-1:0] y_addr_o,
  input  logic [DW-1:0] y_data_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o
);
  logic          accept, busy, zero, fin;
  logic          iss_v, iss_l;
  logic [IW-1:0] iss_idx;
  logic [DW-1:0] scal_q, mul_in, add_in;
  logic          mul_v, mul_l, add_v, add_l;
  logic [IW-1:0] mul_idx, add_idx;
  logic [DW-1:0] mul_d, add_d;
  logic          done_q;

  vmac_seq #(.MAX_LEN(MAX_LEN), .IW(IW), .LW(LW)) u_seq (
    .clk_i, .rst_ni, .start_i, .len_i,
    .fin_i        (fin),
    .accept_o     (accept),
    .busy_o       (busy),
    .zero_o       (zero),
    .issue_valid_o(iss_v),
    .issue_last_o (iss_l),
    .issue_idx_o  (iss_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     scal_q <= '0;
    else if (accept) scal_q <= scalar_i;
  end

  assign x_addr_o = iss_idx;
  assign mul_in   = scal_q * x_data_i;

  vmac_pipe #(.LAT(MUL_LAT), .DW(DW), .IW(IW)) u_mul (
    .clk_i, .rst_ni,
    .in_valid_i (iss_v),
    .in_last_i  (iss_l),
    .in_idx_i   (iss_idx),
    .in_data_i  (mul_in),
    .out_valid_o(mul_v),
    .out_last_o (mul_l),
    .out_idx_o  (mul_idx),
    .out_data_o (mul_d)
  );

  // chaining: Y is fetched for the product leaving the multiplier this cycle
  assign y_addr_o = mul_idx;
  assign add_in   = mul_d + y_data_i;

  vmac_pipe #(.LAT(ADD_LAT), .DW(DW), .IW(IW)) u_add (
    .clk_i, .rst_ni,
    .in_valid_i (mul_v),
    .in_last_i  (mul_l),
    .in_idx_i   (mul_idx),
    .in_data_i  (add_in),
    .out_valid_o(add_v),
    .out_last_o (add_l),
    .out_idx_o  (add_idx),
    .out_data_o (add_d)
  );

  assign fin = add_v & add_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= zero | fin;
  end

  assign wr_en_o   = add_v;
  assign wr_addr_o = add_idx;
  assign wr_data_o = add_d;
  assign done_o    = done_q;
endmodule

// File: rtl/vmac_chain_chk.sv
module vmac_chain_chk #(
  parameter int DW      = 64,
  parameter int MAX_LEN = 64,
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [LW-1:0] len_i,
  input logic          done_o,
  input logic          wr_en_o,
  input logic [IW-1:0] wr_addr_o,
  input logic          busy_i,
  input logic [DW-1:0] scal_i
);
  AST_WR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + IW'(1))); // R2
  AST_WR_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_i); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o); // R4
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && len_i == '0) |=> (!busy_i ##1 (done_o && !wr_en_o))); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(scal_i)); // R6
endmodule

bind vmac_chain vmac_chain_chk #(.DW(DW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .len_i     (len_i),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .busy_i    (busy),
  .scal_i    (scal_q)
);

// File: tb/sim_vmac_chain.sv
`timescale 1ns/1ps
module sim_vmac_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  len = '0;
  logic [63:0] scal = '0;
  logic [5:0]  x_addr, y_addr, wr_addr;
  logic [63:0] x_data, y_data, wr_data;
  logic        wr_en, done;

  logic [63:0] xm [64];
  logic [63:0] ym [64];
  logic [63:0] exp_d [64];
  int cyc = 0, t0 = 0, run_len = 0, wr_cnt = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign x_data = xm[x_addr];
  assign y_data = ym[y_addr];

  vmac_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .scalar_i(scal),
    .x_addr_o(x_addr), .x_data_i(x_data), .y_addr_o(y_addr), .y_data_i(y_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, expv, cyc - t0);
    end
  endtask

  // write monitor: R1 data/address, R2 ordering, R3 timing
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (wr_cnt >= run_len) chk(1'b0, "R2 extra write", 64'(wr_cnt), 64'(run_len));
      else begin
        chk(wr_addr == 6'(wr_cnt), "R1 write address", 64'(wr_addr), 64'(wr_cnt));
        chk(wr_data == exp_d[wr_cnt], "R1 write data", wr_data, exp_d[wr_cnt]);
        chk((cyc - t0) == 13 + wr_cnt, "R3 write timing", 64'(cyc - t0), 64'(13 + wr_cnt));
      end
      wr_cnt++;
    end
  end

  task automatic fill(input logic [63:0] xb, input logic [63:0] yb);
    for (int i = 0; i < 64; i++) begin
      xm[i] = xb + 64'(i) * 64'h0000_0001_0000_0003;
      ym[i] = yb - 64'(i) * 64'h0000_0000_0011_0000;
    end
  endtask

  task automatic launch(input int n, input logic [63:0] a);
    run_len = (n > 64) ? 64 : n;
    for (int i = 0; i < 64; i++) exp_d[i] = a * xm[i] + ym[i];
    wr_cnt = 0;
    @(negedge clk);
    start = 1'b1; len = 7'(n); scal = a;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_done(input int exp_k, input string req);
    int k;
    k = 0;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    chk(done == 1'b1 && (cyc - t0) == exp_k, req, 64'(cyc - t0), 64'(exp_k));
    chk(wr_cnt == run_len, "R2 write count", 64'(wr_cnt), 64'(run_len));
    @(negedge clk);
    chk(done == 1'b0, "R4 done pulse width", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && wr_en == 1'b0, "R7 in reset", {done, wr_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && wr_en == 1'b0, "R7 after reset", {done, wr_en}, 0);
  endtask

  task automatic t_short;
    fill(64'h10, 64'h1000_0000);
    launch(4, 64'd5);
    wait_done(4 + 13, "R4 done len4");
  endtask

  task automatic t_single;
    fill(64'h7, 64'h3);
    launch(1, 64'd9);
    wait_done(1 + 13, "R4 done len1");
  endtask

  task automatic t_full_wrap;
    fill(64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_0000_0000);
    launch(64, 64'hFFFF_FFFF_FFFF_FFFD);
    wait_done(64 + 13, "R4 done len64");
  endtask

  task automatic t_zero;
    launch(0, 64'd3);
    wait_done(1, "R5 zero-length done");
  endtask

  task automatic t_clamp;
    fill(64'h55, 64'h99);
    launch(100, 64'd2);
    wait_done(77, "R9 clamped done");
  endtask

  task automatic t_ignore;
    fill(64'h20, 64'h400);
    launch(8, 64'd3);
    repeat (3) @(negedge clk);
    start = 1'b1; len = 7'd2; scal = 64'd99;  // R6 restart attempt, R8 operand change
    @(negedge clk);
    start = 1'b0; len = 7'd50; scal = 64'd77;
    wait_done(8 + 13, "R6 done unaffected");
  endtask

  task automatic t_back_to_back;
    fill(64'h1, 64'h2);
    launch(3, 64'd4);
    wait_done(3 + 13, "R4 done first of pair");
    launch(5, 64'd6);
    wait_done(5 + 13, "R8 done second of pair");
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fill(64'h0, 64'h0);
    repeat (3) @(negedge clk);
    t_reset;
    t_short;
    t_single;
    t_full_wrap;
    t_zero;
    t_clamp;
    t_ignore;
    t_back_to_back;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule